// File: doc/BRIEF.md
# Dual-Register NCO Phase-to-Amplitude Datapath

This block is the digital core of a numerically controlled oscillator. A 28-bit phase accumulator advances on every clock by a frequency word taken from one of two frequency registers. One of two 12-bit phase offsets is added to the top twelve accumulator bits, and the sum addresses a sine lookup that returns a 10-bit offset-binary amplitude. The accumulator MSB is also brought out as a one-bit square/sign output. The output frequency is `word * f_clk / 2^28`.

A command decoder outside the block writes the four registers through per-register write strobes and a shared data bus. Two select inputs switch between the register pairs at any time, and the accumulator keeps its value when they do. A hold input clears the accumulator and parks the outputs at midscale. After hold is released, samples reach the output a parameterised number of clocks later, with a default of seven.

Top module: `nco_phase_path`

## Requirements
- R1: While `hold` is sampled high at a clock edge, the accumulator is cleared to zero, and after that edge `amp` is 512 and `sign_out` is 0.
- R2: Let edge k be the k-th consecutive edge with `hold` low. After edges 1 to LAT-1 (LAT=7 by default), `amp` is 512 and `sign_out` is 0. After edge LAT and later edges, the outputs carry data.
- R3: At each edge with `hold` low, the accumulator becomes (accumulator + selected frequency word) mod 2^28. `frq_sel`=0 selects frequency register 0 and `frq_sel`=1 selects frequency register 1.
- R4: The lookup address is (accumulator bits 27:16 + selected phase register) mod 4096. `ph_sel`=0 selects phase register 0 and `ph_sel`=1 selects phase register 1.
- R5: For lookup address p, the amplitude is 512 + round(511·sin(2πp/4096)), rounding half away from zero. Every value lies in 1..1023, and address 0 gives 512.
- R6: `sign_out` is bit 27 of the same accumulator value that formed the displayed address, so it stays aligned with `amp`.
- R7: A high `frq_we[i]` (or `ph_we[i]`) at an edge loads `frq_wdata` (or `ph_wdata`) into register i. The new value is used from the following edge onward, and the accumulator contents are not changed by the write.
- R8: A low `rst_n` immediately clears all four registers and the accumulator, and forces `amp` to 512 and `sign_out` to 0.
- R9: Changing `frq_sel` or `ph_sel` while running is phase-continuous: the accumulator continues from its present value.
- R10: Sample timing: the output after edge k (k ≥ LAT) shows the accumulator value that existed before edge k-LAT+1, offset by the phase register selected at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | Synchronous hold: clear accumulator, output midscale |
| frq_sel | input | 1 | Frequency register select |
| ph_sel | input | 1 | Phase register select |
| frq_we | input | 2 | Write strobes, one per frequency register |
| frq_wdata | input | 28 | Frequency write data |
| ph_we | input | 2 | Write strobes, one per phase register |
| ph_wdata | input | 12 | Phase write data |
| amp | output | 10 | Offset-binary sine amplitude |
| sign_out | output | 1 | Delayed accumulator MSB (square/sign) |

## Verification
The hardest thing to reach from the ports is coverage of all 4096 lookup addresses together with accumulator wrap and MSB toggling. In normal use the top twelve bits of a 28-bit accumulator move slowly. The stimulus therefore programs a word of exactly 2^16, so the address steps by one on every clock and the whole table is swept in 4096 cycles. Large words such as 2^27+1 and 0xFF00000 then force the MSB to toggle and the accumulator to wrap within a few clocks. Selects and register writes are changed between edges while a bench-side accumulator tracks the expected sample stream.

// File: rtl/nco_pkg.sv
package nco_pkg;

   localparam real TWO_PI = 6.283185307179586;

   // Rounded scale*sin(2*pi*p/2^pw), rounding half away from zero.
   function automatic int sine_round(input int p, input int pw, input int scale);
      real x;
      x = real'(scale) * $sin(TWO_PI * real'(p) / real'(2 ** pw));
      if (x >= 0.0) return $rtoi(x + 0.5);
      return -$rtoi(0.5 - x);
   endfunction

endpackage

// File: rtl/nco_regs.sv
module nco_regs #(
   parameter int W = 28,
   parameter int N = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N-1:0]        we,
   input  logic [W-1:0]        wdata,
   output logic [N-1:0][W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         for (int i = 0; i < N; i++) begin
            if (we[i]) q[i] <= wdata;
         end
      end
   end

endmodule

// File: rtl/nco_acc.sv
module nco_acc #(
   parameter int W = 28
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold,
   input  logic [W-1:0] inc,
   output logic [W-1:0] acc
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc <= '0;
      else if (hold)  acc <= '0;
      else            acc <= acc + inc;
   end

endmodule

// File: rtl/nco_sine_lut.sv
module nco_sine_lut
   import nco_pkg::*;
#(
   parameter int PH_W       = 12,
   parameter int AMP_W      = 10,
   parameter bit FULL_TABLE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PH_W-1:0]  addr,
   output logic [AMP_W-1:0] amp
);

   localparam int N     = 1 << PH_W;
   localparam int QN    = N / 4;
   localparam int MID   = 1 << (AMP_W - 1);
   localparam int SCALE = MID - 1;

   logic [AMP_W-1:0] amp_c;

   if (FULL_TABLE) begin : g_full
      logic [AMP_W-1:0] tab [N];
      for (genvar i = 0; i < N; i++) begin : g_e
         localparam int V = MID + sine_round(i, PH_W, SCALE);
         assign tab[i] = AMP_W'(V);
      end
      assign amp_c = tab[addr];
   end else begin : g_quarter
      logic [AMP_W-2:0] qtab [QN+1];
      for (genvar i = 0; i <= QN; i++) begin : g_e
         localparam int V = sine_round(i, PH_W, SCALE);
         assign qtab[i] = (AMP_W-1)'(V);
      end

      logic [1:0]       quad;
      logic [PH_W-3:0]  k;
      logic [PH_W-2:0]  idx;
      logic [AMP_W-2:0] mag;

      always_comb begin
         quad  = addr[PH_W-1 -: 2];
         k     = addr[PH_W-3:0];
         // Odd quadrants run the quarter table backwards.
         idx   = quad[0] ? ((PH_W-1)'(QN) - {1'b0, k}) : {1'b0, k};
         mag   = qtab[idx];
         // Lower half period mirrors below midscale.
         amp_c = quad[1] ? (AMP_W'(MID) - {1'b0, mag})
                         : (AMP_W'(MID) + {1'b0, mag});
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) amp <= AMP_W'(MID);
      else        amp <= amp_c;
   end

endmodule

// File: rtl/nco_delay.sv
module nco_delay #(
   parameter int W = 11,
   parameter int D = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   if (D == 0) begin : g_wire
      assign dout = din;
   end else begin : g_pipe
      logic [W-1:0] st [D];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < D; i++) st[i] <= '0;
         end else begin
            st[0] <= din;
            for (int i = 1; i < D; i++) st[i] <= st[i-1];
         end
      end
      assign dout = st[D-1];
   end

endmodule

// File: rtl/nco_phase_path.sv
module nco_phase_path
   import nco_pkg::*;
#(
   parameter int ACC_W      = 28,
   parameter int PH_W       = 12,
   parameter int AMP_W      = 10,
   parameter int LAT        = 7,
   parameter bit FULL_TABLE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             frq_sel,
   input  logic             ph_sel,
   input  logic [1:0]       frq_we,
   input  logic [ACC_W-1:0] frq_wdata,
   input  logic [1:0]       ph_we,
   input  logic [PH_W-1:0]  ph_wdata,
   output logic [AMP_W-1:0] amp,
   output logic             sign_out
);

   localparam int DLY = LAT - 2;
   localparam logic [AMP_W-1:0] MID = AMP_W'(1 << (AMP_W - 1));

   initial begin
      if (LAT < 3)        $fatal(1, "LAT must be at least 3");
      if (PH_W < 4)       $fatal(1, "PH_W must be at least 4");
      if (ACC_W < PH_W)   $fatal(1, "ACC_W must not be below PH_W");
      if (AMP_W < 3)      $fatal(1, "AMP_W must be at least 3");
   end

   logic [1:0][ACC_W-1:0] frq_q;
   logic [1:0][PH_W-1:0]  ph_q;
   logic [ACC_W-1:0]      acc_q;
   logic [ACC_W-1:0]      inc;
   logic [PH_W-1:0]       offs;

   nco_regs #(.W(ACC_W), .N(2)) u_frq (
      .clk(clk), .rst_n(rst_n), .we(frq_we), .wdata(frq_wdata), .q(frq_q)
   );

   nco_regs #(.W(PH_W), .N(2)) u_ph (
      .clk(clk), .rst_n(rst_n), .we(ph_we), .wdata(ph_wdata), .q(ph_q)
   );

   assign inc  = frq_q[frq_sel];
   assign offs = ph_q[ph_sel];

   nco_acc #(.W(ACC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .hold(hold), .inc(inc), .acc(acc_q)
   );

   // Stage 2: phase offset and MSB capture
   logic [PH_W-1:0] addr_q;
   logic            msb_s2, msb_s3;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         msb_s2 <= 1'b0;
         msb_s3 <= 1'b0;
      end else begin
         addr_q <= acc_q[ACC_W-1 -: PH_W] + offs;
         msb_s2 <= acc_q[ACC_W-1];
         msb_s3 <= msb_s2;
      end
   end

   // Stage 3: registered lookup
   logic [AMP_W-1:0] amp_s3;

   nco_sine_lut #(.PH_W(PH_W), .AMP_W(AMP_W), .FULL_TABLE(FULL_TABLE)) u_lut (
      .clk(clk), .rst_n(rst_n), .addr(addr_q), .amp(amp_s3)
   );

   // Alignment delay
   logic [AMP_W:0] dly_out;

   nco_delay #(.W(AMP_W + 1), .D(DLY)) u_dly (
      .clk(clk), .rst_n(rst_n), .din({msb_s3, amp_s3}), .dout(dly_out)
   );

   // Warm-up qualifier: LAT clean edges after hold release
   logic [LAT-1:0] vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     vld <= '0;
      else if (hold)  vld <= '0;
      else            vld <= {vld[LAT-2:0], 1'b1};
   end

   assign amp      = vld[LAT-1] ? dly_out[AMP_W-1:0] : MID;
   assign sign_out = vld[LAT-1] & dly_out[AMP_W];

endmodule

// File: rtl/nco_phase_path_chk.sv
module nco_phase_path_chk #(
   parameter int ACC_W = 28,
   parameter int PH_W  = 12,
   parameter int AMP_W = 10,
   parameter int LAT   = 7
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  hold,
   input logic                  frq_sel,
   input logic [1:0][ACC_W-1:0] frq_q,
   input logic [ACC_W-1:0]      acc_q,
   input logic [AMP_W-1:0]      amp,
   input logic                  sign_out
);

   localparam logic [AMP_W-1:0] MID = AMP_W'(1 << (AMP_W - 1));

   int unsigned warm;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    warm <= 0;
      else if (hold)                 warm <= 0;
      else if (warm < LAT)           warm <= warm + 1;
   end

   logic [ACC_W-1:0] sel_inc;
   assign sel_inc = frq_sel ? frq_q[1] : frq_q[0];

   // R1
   hold_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (acc_q == '0 && amp == MID && !sign_out));

   // R2
   warmup_amp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm < LAT) |-> (amp == MID));

   // R2
   warmup_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm < LAT) |-> !sign_out);

   // R3
   acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(hold) |-> (acc_q == $past(acc_q) + $past(sel_inc)));

   // R5
   amp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      amp != '0);

endmodule

bind nco_phase_path nco_phase_path_chk #(
   .ACC_W(ACC_W), .PH_W(PH_W), .AMP_W(AMP_W), .LAT(LAT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .hold(hold), .frq_sel(frq_sel),
   .frq_q(frq_q), .acc_q(acc_q), .amp(amp), .sign_out(sign_out)
);

// File: tb/tb_nco_phase_path.sv
`timescale 1ns/1ps
module tb_nco_phase_path;

   localparam int LAT = 7;

   logic        clk = 1'b0;
   logic        rst_n, hold, frq_sel, ph_sel;
   logic [1:0]  frq_we, ph_we;
   logic [27:0] frq_wdata;
   logic [11:0] ph_wdata;
   logic [9:0]  amp;
   logic        sign_out;

   always #2 clk = ~clk;

   nco_phase_path dut (
      .clk(clk), .rst_n(rst_n), .hold(hold), .frq_sel(frq_sel), .ph_sel(ph_sel),
      .frq_we(frq_we), .frq_wdata(frq_wdata), .ph_we(ph_we), .ph_wdata(ph_wdata),
      .amp(amp), .sign_out(sign_out)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // Bench-side model state
   logic [27:0] acc_m;
   logic [27:0] fr_m [2];
   logic [11:0] ph_m [2];
   int          run_cnt;
   int          edge_n;
   logic [11:0] pidx_h [16];
   logic        msb_h [16];

   function automatic int ref_amp(input int p);
      real x;
      x = 511.0 * $sin(6.283185307179586 * real'(p) / 4096.0);
      if (x >= 0.0) return 512 + $rtoi(x + 0.5);
      return 512 - $rtoi(0.5 - x);
   endfunction

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      acc_m = '0;
      fr_m[0] = '0; fr_m[1] = '0;
      ph_m[0] = '0; ph_m[1] = '0;
      run_cnt = 0;
   endtask

   task automatic tick(input string tag);
      int s;
      int ea;
      int es;
      @(posedge clk);
      if (rst_n) begin
         s = edge_n % 16;
         pidx_h[s] = acc_m[27:16] + ph_m[ph_sel];
         msb_h[s]  = acc_m[27];
         edge_n++;
         acc_m   = hold ? 28'd0 : acc_m + fr_m[frq_sel];
         run_cnt = hold ? 0 : ((run_cnt < LAT) ? run_cnt + 1 : run_cnt);
         for (int i = 0; i < 2; i++) begin
            if (frq_we[i]) fr_m[i] = frq_wdata;
            if (ph_we[i])  ph_m[i] = ph_wdata;
         end
      end
      @(negedge clk);
      if (rst_n && run_cnt >= LAT) begin
         s  = (edge_n - LAT) % 16;
         ea = ref_amp(int'(pidx_h[s]));
         es = int'(msb_h[s]);
      end else begin
         ea = 512;
         es = 0;
      end
      check(tag, "amp", int'(amp), ea);
      check(tag, "sign_out", int'(sign_out), es);
   endtask

   task automatic summary();
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; hold = 1'b1; frq_sel = 1'b0; ph_sel = 1'b0;
      frq_we = '0; ph_we = '0; frq_wdata = '0; ph_wdata = '0;
      edge_n = 0;
      model_reset();

      // R8: reset state
      for (int i = 0; i < 3; i++) tick("R8");
      rst_n = 1'b1;
      for (int i = 0; i < 2; i++) tick("R1");

      // R7: load word 2^16 while held
      frq_we = 2'b01; frq_wdata = 28'h0010000;
      tick("R7");
      frq_we = '0;

      // R5: full table sweep, one address per clock
      hold = 1'b0;
      for (int i = 0; i < 4096 + LAT + 2; i++) tick("R5");

      // R1: hold parks outputs; R4: offset 1024 during hold
      hold = 1'b1;
      ph_we = 2'b01; ph_wdata = 12'd1024;
      tick("R1");
      ph_we = '0;
      for (int i = 0; i < 2; i++) tick("R1");

      // R2: warm-up latency, first data is 1023 at edge LAT
      hold = 1'b0;
      for (int i = 0; i < LAT; i++) tick("R2");
      for (int i = 0; i < 20; i++) tick("R4");

      // R3: second frequency register, second phase register
      frq_we = 2'b10; frq_wdata = 28'h0123457;
      ph_we  = 2'b10; ph_wdata  = 12'hABC;
      tick("R7");
      frq_we = '0; ph_we = '0;
      frq_sel = 1'b1; ph_sel = 1'b1;
      for (int i = 0; i < 100; i++) tick("R3");

      // R9: toggling selects while running
      for (int i = 0; i < 300; i++) begin
         if (i % 3 == 0) frq_sel = ~frq_sel;
         if (i % 5 == 0) ph_sel  = ~ph_sel;
         tick("R9");
      end

      // R7: rewrite the active register while running
      frq_sel = 1'b0;
      tick("R7");
      frq_we = 2'b01; frq_wdata = 28'h00A5A5A;
      tick("R7");
      frq_we = '0;
      for (int i = 0; i < 50; i++) tick("R7");

      // R6: MSB toggles every clock
      ph_sel = 1'b0;
      frq_we = 2'b01; frq_wdata = 28'h8000001;
      tick("R6");
      frq_we = '0;
      for (int i = 0; i < 40; i++) tick("R6");

      // R3: modular wrap with a large word
      frq_we = 2'b01; frq_wdata = 28'hFF00000;
      tick("R3");
      frq_we = '0;
      for (int i = 0; i < 60; i++) tick("R3");

      // R10: sample alignment across a one-cycle hold
      hold = 1'b1;
      tick("R1");
      hold = 1'b0;
      for (int i = 0; i < 30; i++) tick("R10");

      // R8: asynchronous reset mid-run clears registers
      rst_n = 1'b0;
      #1;
      check("R8", "amp", int'(amp), 512);
      check("R8", "sign_out", int'(sign_out), 0);
      model_reset();
      for (int i = 0; i < 2; i++) tick("R8");
      rst_n = 1'b1;
      for (int i = 0; i < 50; i++) tick("R8");

      done = 1'b1;
      summary();
      $finish;
   end

endmodule